// File: doc/BRIEF.md
# Five-level level-shifted PWM generator

This block produces the six gate commands for a single-phase inverter that reaches five output levels from one DC source. The inverter has three half-bridge arms. The first arm switches only at the fundamental and follows the sign of the reference. The other two arms feed a pair of coupled inductors. Each carrier period they move between a shared state and one of two redundant single-on states, and these transitions form the intermediate levels.

A signed reference sample enters on a valid/ready port. Four triangular carriers of equal amplitude are stacked in quarter-scale bands that cover the whole signed range. The reference is compared with each carrier. The number of carriers lying below it is the level, from 0 to 4. A mode input sets the relative phase of the carriers. The level, the reference sign and a selector that alternates every carrier period then set the three upper-switch commands. Each lower switch is the inverse of its upper switch, with a programmable dead time inserted before either switch of an arm turns on.

Back-pressure: `ref_ready` is high in every cycle that reset is low, so the block never stalls a sender. A sample is taken in each cycle where `ref_valid` and `ref_ready` are both high. When no sample is taken, the last accepted sample keeps modulating.

Top module: `pwm5_gen`

## Requirements
- R1: The carrier counter runs 0,1,…,P,P-1,…,1 and repeats, so one period lasts 2P clocks, where P is `cfg_period`. Carrier k (k=0..3) spans [-32768+16384k, -16384+16384k]. An in-phase carrier is at its band bottom when the counter is 0. The level is the number of carriers whose value is strictly below the reference.
- R2: `cfg_mode` selects the carrier phasing. 0 (in-phase) keeps all four carriers in phase. 1 (opposed halves) inverts carriers 0 and 1 against carriers 2 and 3. 2 (alternate) inverts carriers 1 and 3, so adjacent bands are opposed. 3 behaves as 0.
- R3: Arm 0 upper gate is on when the accepted reference is zero or positive, and its lower gate is on when the reference is negative.
- R4: The selector toggles each time the counter returns to 0. Single-on state "B" (arm 1 on, arm 2 off) is used when the selector is 0, and "C" (arm 2 on, arm 1 off) when it is 1.
- R5: An arm never has its upper and lower gates on together.
- R6: A synchronous reset turns all six gates off and holds `ref_ready` low.
- R7: With `cfg_dead` = D ≥ 1, each change of an arm's command leaves both of its gates off for exactly D clocks before the new side turns on. With D = 0 the arm switches directly, and its lower gate is always the inverse of its upper gate.
- R8: Non-negative reference: level 4 turns arms 1 and 2 both off, level 3 uses the single-on state, and level 2 turns both on.
- R9: Negative reference: level 2 turns arms 1 and 2 both off, level 1 uses the single-on state, and level 0 turns both on.
- R10: `ref_ready` is high in every cycle outside reset. A sample is taken only when `ref_valid` is high. Without a valid sample the block keeps the previous reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | Carrier phasing: 0 in-phase, 1 opposed halves, 2 alternate, 3 as 0 |
| cfg_period | input | CNT_W | Carrier half period P in clocks |
| cfg_dead | input | DT_W | Dead time D in clocks |
| ref_valid | input | 1 | Reference sample valid |
| ref_ready | output | 1 | Reference sample accepted this cycle when valid |
| ref_data | input | REF_W | Signed reference sample |
| gate_hi | output | 3 | Upper-switch gates, bit k for arm k |
| gate_lo | output | 3 | Lower-switch gates, bit k for arm k |

## Verification
The bench drives each of the four carrier bands in every phasing mode. For each case it checks whether the single-on state flips from B to C directly inside one pulse. That happens only when the reference crosses an in-phase region around the counter reset point. A carrier inverted in the wrong band, or a swapped mode code, therefore shows up as a missing or extra direct flip. In each band it also checks that the state forbidden there never appears and that both single-on states occur, so a level table that is off by one, or a selector that never toggles, is caught. Exact duty counts over whole periods at two carrier periods expose an off-by-one in the triangle turnaround or in the comparator threshold. The measured gate gaps expose a dead-time counter that is off by one.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;
  typedef enum logic [1:0] {
    MODE_INPHASE  = 2'd0,
    MODE_OPPHALF  = 2'd1,
    MODE_ALTERN   = 2'd2,
    MODE_RESERVED = 2'd3
  } carrier_mode_e;

  localparam int NUM_CARRIERS = 4;
  localparam int LEVEL_W      = 3;
  localparam int NUM_ARMS     = 3;
  localparam int ARM_FUND     = 0;
  localparam int ARM_B        = 1;
  localparam int ARM_C        = 2;
endpackage

// File: rtl/pwm5_carrier.sv
module pwm5_carrier #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] tri_cnt,
  output logic             sel
);
  logic going_up;

  // Up/down triangle; the selector flips when the count lands on zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      tri_cnt  <= '0;
      going_up <= 1'b1;
      sel      <= 1'b0;
    end else if (going_up) begin
      if (tri_cnt >= period) begin
        going_up <= 1'b0;
        if (tri_cnt != '0) tri_cnt <= tri_cnt - CNT_W'(1);
      end else begin
        tri_cnt <= tri_cnt + CNT_W'(1);
      end
    end else begin
      if (tri_cnt <= CNT_W'(1)) begin
        tri_cnt  <= '0;
        going_up <= 1'b1;
        sel      <= ~sel;
      end else begin
        tri_cnt <= tri_cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pwm5_level.sv
module pwm5_level
  import pwm5_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int CNT_W = 16
) (
  input  logic signed [REF_W-1:0] ref_s,
  input  logic [CNT_W-1:0]        tri_cnt,
  input  logic [CNT_W-1:0]        period,
  input  carrier_mode_e           mode,
  output logic [LEVEL_W-1:0]      level
);
  localparam int BAND   = (1 << REF_W) / NUM_CARRIERS;
  localparam int OFF_W  = REF_W + 2;
  localparam int PROD_W = REF_W + CNT_W + 2;

  logic [NUM_CARRIERS-1:0] above;

  for (genvar k = 0; k < NUM_CARRIERS; k++) begin : g_band
    localparam logic signed [OFF_W-1:0] BOTTOM = OFF_W'(-(1 << (REF_W - 1)) + k * BAND);
    localparam logic signed [OFF_W-1:0] BAND_S = OFF_W'(BAND);

    logic signed [OFF_W-1:0] off;
    logic                    inv;
    logic [CNT_W-1:0]        car;
    logic [PROD_W-1:0]       lhs;
    logic [PROD_W-1:0]       rhs;
    logic                    hit;

    always_comb begin
      off = OFF_W'(ref_s) - BOTTOM;
      inv = ((mode == MODE_OPPHALF) && (k < NUM_CARRIERS / 2)) ||
            ((mode == MODE_ALTERN) && ((k % 2) == 1));
      if (inv) car = (tri_cnt >= period) ? '0 : (period - tri_cnt);
      else     car = tri_cnt;
      // reference offset / BAND  >  carrier / period, cross-multiplied
      lhs = PROD_W'(off[OFF_W-2:0]) * PROD_W'(period);
      rhs = PROD_W'(car) * PROD_W'(BAND);
      if (off <= OFF_W'(0))    hit = 1'b0;
      else if (off >= BAND_S)  hit = 1'b1;
      else                     hit = (lhs > rhs);
    end

    assign above[k] = hit;
  end

  always_comb begin
    level = '0;
    for (int i = 0; i < NUM_CARRIERS; i++) level = level + LEVEL_W'(above[i]);
  end
endmodule

// File: rtl/pwm5_map.sv
module pwm5_map
  import pwm5_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [LEVEL_W-1:0]  level,
  input  logic                ref_neg,
  input  logic                sel,
  output logic [NUM_ARMS-1:0] cmd
);
  logic [NUM_ARMS-1:0] nxt;

  always_comb begin
    nxt           = '0;
    nxt[ARM_FUND] = ~ref_neg;
    unique case (level)
      LEVEL_W'(4): begin nxt[ARM_B] = 1'b0;     nxt[ARM_C] = 1'b0;     end
      LEVEL_W'(3),
      LEVEL_W'(1): begin nxt[ARM_B] = ~sel;     nxt[ARM_C] = sel;      end
      LEVEL_W'(2): begin nxt[ARM_B] = ~ref_neg; nxt[ARM_C] = ~ref_neg; end
      default:     begin nxt[ARM_B] = 1'b1;     nxt[ARM_C] = 1'b1;     end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cmd <= '0;
    else     cmd <= nxt;
  end
endmodule

// File: rtl/pwm5_deadtime.sv
module pwm5_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd,
  input  logic [DT_W-1:0] dead,
  output logic            hi,
  output logic            lo
);
  logic            applied;
  logic [DT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      applied <= 1'b0;
      cnt     <= '0;
      hi      <= 1'b0;
      lo      <= 1'b0;
    end else if (cmd != applied) begin
      applied <= cmd;
      if (dead == '0) begin
        cnt <= '0;
        hi  <= cmd;
        lo  <= ~cmd;
      end else begin
        cnt <= dead - DT_W'(1);
        hi  <= 1'b0;
        lo  <= 1'b0;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - DT_W'(1);
      hi  <= 1'b0;
      lo  <= 1'b0;
    end else begin
      hi <= applied;
      lo <= ~applied;
    end
  end
endmodule

// File: rtl/pwm5_gen.sv
module pwm5_gen
  import pwm5_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [DT_W-1:0]  cfg_dead,
  input  logic             ref_valid,
  output logic             ref_ready,
  input  logic [REF_W-1:0] ref_data,
  output logic [2:0]       gate_hi,
  output logic [2:0]       gate_lo
);
  logic signed [REF_W-1:0] ref_q;
  logic [CNT_W-1:0]        tri_cnt;
  logic                    sel;
  logic [LEVEL_W-1:0]      level;
  logic [NUM_ARMS-1:0]     cmd;
  carrier_mode_e           mode;

  assign ref_ready = ~rst;
  assign mode      = carrier_mode_e'(cfg_mode);

  always_ff @(posedge clk) begin
    if (rst)                         ref_q <= '0;
    else if (ref_valid && ref_ready) ref_q <= ref_data;
  end

  pwm5_carrier #(.CNT_W(CNT_W)) carrier_i (
    .clk(clk), .rst(rst), .period(cfg_period), .tri_cnt(tri_cnt), .sel(sel)
  );

  pwm5_level #(.REF_W(REF_W), .CNT_W(CNT_W)) level_i (
    .ref_s(ref_q), .tri_cnt(tri_cnt), .period(cfg_period), .mode(mode), .level(level)
  );

  pwm5_map map_i (
    .clk(clk), .rst(rst), .level(level), .ref_neg(ref_q[REF_W-1]), .sel(sel), .cmd(cmd)
  );

  for (genvar a = 0; a < NUM_ARMS; a++) begin : g_arm
    pwm5_deadtime #(.DT_W(DT_W)) dt_i (
      .clk(clk), .rst(rst), .cmd(cmd[a]), .dead(cfg_dead),
      .hi(gate_hi[a]), .lo(gate_lo[a])
    );
  end
endmodule

// File: rtl/pwm5_gen_chk.sv
module pwm5_gen_chk #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cfg_period,
  input logic [DT_W-1:0]  cfg_dead,
  input logic [2:0]       gate_hi,
  input logic [2:0]       gate_lo,
  input logic [CNT_W-1:0] tri_cnt,
  input logic             sel
);
  logic seen_edge = 1'b0;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  // R1: the count never leaves [0, P] once inside it
  assert_carrier_range_R1: assert property (@(posedge clk) disable iff (rst)
    (tri_cnt <= cfg_period) |=> (tri_cnt <= $past(cfg_period)));

  // R4: the selector only moves together with the counter reaching zero
  assert_sel_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel) |-> (tri_cnt == '0));

  // R5: no arm conducts on both sides
  assert_no_shoot_R5: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == 3'b000);

  // R6: one edge in reset leaves all six gates off
  assert_reset_off_R6: assert property (@(posedge clk)
    (seen_edge && $past(rst)) |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  for (genvar a = 0; a < 3; a++) begin : g_arm_chk
    // R7: with a dead time, a side never turns on straight from the other
    assert_dead_gap_hi_R7: assert property (@(posedge clk) disable iff (rst)
      (($past(cfg_dead) != '0) && $rose(gate_hi[a])) |-> !$past(gate_lo[a]));
    assert_dead_gap_lo_R7: assert property (@(posedge clk) disable iff (rst)
      (($past(cfg_dead) != '0) && $rose(gate_lo[a])) |-> !$past(gate_hi[a]));
  end
endmodule

bind pwm5_gen pwm5_gen_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_dead(cfg_dead),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .tri_cnt(tri_cnt), .sel(sel)
);

// File: tb/pwm5_gen_tb_top.sv
`timescale 1ns/1ps
module pwm5_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'd0;
  logic [15:0] cfg_period = 16'd16;
  logic [7:0]  cfg_dead = 8'd0;
  logic        ref_valid = 1'b0;
  logic        ref_ready;
  logic [15:0] ref_data = '0;
  logic [2:0]  gate_hi;
  logic [2:0]  gate_lo;

  int checks = 0;
  int errors = 0;
  int overlap = 0;

  always #2.5 clk = ~clk;

  pwm5_gen dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_period(cfg_period),
    .cfg_dead(cfg_dead), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_data(ref_data), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always @(negedge clk) if (!rst && ((gate_hi & gate_lo) != 3'b000)) overlap++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic send_ref(input int v);
    @(negedge clk);
    ref_data  = 16'(v);
    ref_valid = 1'b1;
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic t_reset();
    int bad = 0;
    rst = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (gate_hi != 3'b000 || gate_lo != 3'b000 || ref_ready) bad++;
    end
    chk(bad == 0, "R6 gates off and ready low in reset", bad, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ref_ready == 1'b1, "R10 ready after reset", int'(ref_ready), 1);
  endtask

  task automatic t_sign();
    int n = 0;
    cfg_dead = 8'd2; cfg_period = 16'd16; cfg_mode = 2'd0;
    send_ref(20000);
    repeat (80) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (gate_hi[0] && !gate_lo[0]) n++;
    end
    chk(n == 64, "R3 arm0 high for positive reference", n, 64);
    send_ref(-20000);
    repeat (80) @(negedge clk);
    n = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (!gate_hi[0] && gate_lo[0]) n++;
    end
    chk(n == 64, "R3 arm0 low for negative reference", n, 64);
  endtask

  task automatic t_hold();
    int n = 0;
    send_ref(12000);
    @(negedge clk);
    ref_data = 16'(-12000);
    repeat (60) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (gate_hi[0]) n++;
    end
    chk(n == 64, "R10 data without valid ignored", n, 64);
  endtask

  // States below are (arm1 upper, arm2 upper) packed as {b,c}.
  task automatic t_band(input logic [1:0] mode, input int refv, input bit exp_direct,
                        input logic [1:0] forbid, input string tag);
    int nforb = 0, ndirect = 0, nb = 0, nc = 0, ncomp = 0;
    logic [1:0] st, prev;
    cfg_dead = 8'd0; cfg_period = 16'd16; cfg_mode = mode;
    send_ref(refv);
    repeat (101) @(negedge clk);
    prev = {gate_hi[1], gate_hi[2]};
    for (int i = 0; i < 192; i++) begin
      @(negedge clk);
      st = {gate_hi[1], gate_hi[2]};
      if (st == forbid) nforb++;
      if (st == 2'b10) nb++;
      if (st == 2'b01) nc++;
      if ((prev == 2'b10 && st == 2'b01) || (prev == 2'b01 && st == 2'b10)) ndirect++;
      if ((gate_hi[1] ^ gate_lo[1]) && (gate_hi[2] ^ gate_lo[2])) ncomp++;
      prev = st;
    end
    chk(nforb == 0, {tag, " R8/R9 forbidden state absent"}, nforb, 0);
    chk((ndirect > 0) == exp_direct, {tag, " R2 direct single-on flip"}, ndirect, int'(exp_direct));
    chk(nb > 0 && nc > 0, {tag, " R4 both single-on states used"}, nb * 1000 + nc, 1);
    chk(ncomp == 192, {tag, " R7 zero dead time complementary"}, ncomp, 192);
  endtask

  task automatic t_duty();
    int n = 0, starts = 0;
    logic prev;
    // R1/R8: P=16, ref offset 3/4 of band 3 -> both off while count < 12: 23 of 32 clocks
    cfg_dead = 8'd0; cfg_period = 16'd16; cfg_mode = 2'd0;
    send_ref(28672);
    repeat (100) @(negedge clk);
    prev = gate_lo[1] && gate_lo[2];
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (gate_lo[1] && gate_lo[2]) begin
        n++;
        if (!prev) starts++;
      end
      prev = gate_lo[1] && gate_lo[2];
    end
    chk(n == 184, "R1 R8 duty at P=16", n, 184);
    chk(starts == 8, "R1 one pulse per carrier period", starts, 8);
    // R1/R8: P=10, ref mid band 2 -> single-on while count < 5: 9 of 20; both on 11 of 20
    cfg_period = 16'd10;
    send_ref(8192);
    repeat (100) @(negedge clk);
    n = 0;
    for (int i = 0; i < 160; i++) begin
      @(negedge clk);
      if (gate_hi[1] && gate_hi[2]) n++;
    end
    chk(n == 88, "R1 R8 duty at P=10", n, 88);
  endtask

  task automatic t_dead();
    int gap = 0, got = 0, bad = 0;
    bit counting = 1'b0;
    logic ph, pl;
    cfg_dead = 8'd3; cfg_period = 16'd16; cfg_mode = 2'd0;
    send_ref(8192);
    repeat (100) @(negedge clk);
    ph = gate_hi[1]; pl = gate_lo[1];
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (counting) begin
        if (!gate_hi[1] && !gate_lo[1]) gap++;
        else begin
          if (gap != 3) bad++;
          got++;
          counting = 1'b0;
        end
      end else if ((ph && !gate_hi[1]) || (pl && !gate_lo[1])) begin
        counting = 1'b1;
        gap = 1;
      end
      ph = gate_hi[1]; pl = gate_lo[1];
    end
    chk(bad == 0, "R7 dead gap of 3 clocks", bad, 0);
    chk(got >= 4, "R7 gaps observed", got, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_sign();
    t_hold();
    t_band(2'd0,  24576, 1'b0, 2'b11, "band3 in-phase");
    t_band(2'd1,  24576, 1'b0, 2'b11, "band3 opposed");
    t_band(2'd2,  24576, 1'b1, 2'b11, "band3 alternate");
    t_band(2'd3,  24576, 1'b0, 2'b11, "band3 code3");
    t_band(2'd0,   8192, 1'b1, 2'b00, "band2 in-phase");
    t_band(2'd0,  -8192, 1'b0, 2'b11, "band1 in-phase");
    t_band(2'd1,  -8192, 1'b1, 2'b11, "band1 opposed");
    t_band(2'd2,  -8192, 1'b1, 2'b11, "band1 alternate");
    t_band(2'd0, -24576, 1'b1, 2'b00, "band0 in-phase");
    t_band(2'd1, -24576, 1'b0, 2'b00, "band0 opposed");
    t_band(2'd2, -24576, 1'b1, 2'b00, "band0 alternate");
    t_duty();
    t_dead();
    chk(overlap == 0, "R5 no upper/lower overlap", overlap, 0);
    summary();
    $finish;
  end
endmodule